// File: doc/BRIEF.md
# Accumulating ADC Result Formatter

This block sits behind a successive-approximation converter and turns a stream of 12-bit conversion results into one 16-bit data word. Software programs how many conversions make up a set (one, four, eight or sixteen). The block adds every delivered sample of the set into a running sum. When the last sample of the set arrives, it publishes the total and raises a one-cycle completion pulse. The running sum and sample count then return to zero, so the next set starts from nothing. The sum is never shifted to form an average.

The published word is normally right-justified. For a single conversion it can instead be placed in the upper twelve bits, with four zero bits below. If left placement is requested with a repeat count above one, the block uses right placement instead, so that a summed value is never cut off.

Conversion start, channel selection, the analog path and window comparison are handled elsewhere. This block only counts and sums the samples it is given. A clear input lets the surrounding logic throw away a set that was interrupted, for example when the converter was switched off partway through.

Top module: `adcacc_formatter`

## Requirements
- R1: After reset the data word reads 0x0000 and the completion pulse is low.
- R2: The repeat field sets the set size: 2'b00 means 1 sample, 2'b01 means 4, 2'b10 means 8 and 2'b11 means 16. The word takes the sum of the samples of the set. The completion pulse is raised on the clock edge that accepts the set's last sample, so both are visible in the following cycle.
- R3: With right placement, the sum occupies the word from bit 0 upward with no wrap-around. A 1-sample set leaves bits 15:12 zero, a 4-sample set leaves bits 15:14 zero, an 8-sample set leaves bit 15 zero, and sixteen samples of 4095 give 0xFFF0.
- R4: With left placement (justify input 1) and a 1-sample set, the word is the sample in bits 15:4, and bits 3:0 are zero.
- R5: With the justify input at 1 and a repeat field other than 2'b00, the word is right-placed, exactly as if the justify input were 0.
- R6: The completion pulse lasts one cycle for each finished set. It is never raised for a sample that is not the last of its set, nor in a cycle without an accepted sample.
- R7: After a set completes, the running sum and count restart at zero, so consecutive sets are independent.
- R8: Clear zeroes the data word, the running sum and the running count on the next edge, and it wins over a sample accepted in the same cycle.
- R9: While the enable input is low, valid samples are ignored: they are neither counted nor summed.
- R10: Between completion pulses, and apart from a clear, the data word holds its value while samples of an unfinished set are being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enable; samples are accepted only while it is high |
| clear | input | 1 | Manual clear of the word, the sum and the count |
| samp_vld | input | 1 | One-cycle strobe marking a new conversion result |
| samp_data | input | 12 | Conversion result |
| rpt_sel | input | 2 | Repeat-count field (sets the samples per set) |
| ljust_sel | input | 1 | Requests left placement (honoured only for a 1-sample set) |
| word_hi | output | 8 | Upper byte of the data word |
| word_lo | output | 8 | Lower byte of the data word |
| set_done | output | 1 | One-cycle pulse when a set completes |

## Verification
The assertions check on every cycle that:
- the word stays put between completion pulses;
- a completion pulse always follows an accepted sample;
- the sum and count return to zero after a final sample or a clear;
- the running sum never wraps;
- the low nibble is zero whenever left placement was used;
- a disabled input leaves the count untouched.

Only the bench's scenarios can show that the published value equals the sum of the samples for each of the four set sizes. The same holds for the fallback from left to right placement, and for a cleared partial set contributing nothing to the following total.

// File: rtl/adcacc_pkg.sv
package adcacc_pkg;

  localparam int SAMPLE_W = 12;
  localparam int WORD_W   = 16;
  localparam int RPT_W    = 2;
  localparam int CNT_W    = 5;

  // Number of samples that form one set for a given repeat field.
  function automatic logic [CNT_W-1:0] rpt_count(input logic [RPT_W-1:0] sel);
    logic [CNT_W-1:0] n;
    case (sel)
      2'b00:   n = CNT_W'(1);
      2'b01:   n = CNT_W'(4);
      2'b10:   n = CNT_W'(8);
      default: n = CNT_W'(16);
    endcase
    return n;
  endfunction

  // Left placement is honoured only for a single-sample set.
  function automatic logic lj_effective(input logic [RPT_W-1:0] sel, input logic lj);
    return lj && (sel == '0);
  endfunction

endpackage

// File: rtl/adcacc_count.sv
module adcacc_count
  import adcacc_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int RW = RPT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  input  logic [RW-1:0] rpt_sel,
  output logic [CW-1:0] cnt_q,
  output logic          last_take
);

  logic [CW-1:0] target;
  logic [CW-1:0] target_m1;

  always_comb begin
    target    = CW'(rpt_count(rpt_sel));
    target_m1 = target - CW'(1);
    last_take = take && (cnt_q >= target_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clear)     cnt_q <= '0;
    else if (last_take) cnt_q <= '0;
    else if (take)      cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> (cnt_q == '0)); // R7

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/adcacc_sum.sv
module adcacc_sum #(
  parameter int SW = adcacc_pkg::SAMPLE_W,
  parameter int WW = adcacc_pkg::WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  input  logic          last_take,
  input  logic [SW-1:0] sample,
  output logic [WW-1:0] sum_next
);

  localparam int EXT_W = WW - SW;

  logic [WW-1:0] acc_q;

  function automatic logic [WW-1:0] widen(input logic [SW-1:0] s);
    return {{EXT_W{1'b0}}, s};
  endfunction

  always_comb sum_next = acc_q + widen(sample);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (clear)     acc_q <= '0;
    else if (last_take) acc_q <= '0;
    else if (take)      acc_q <= sum_next;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (sum_next >= acc_q)); // R3

  AST_ACC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (last_take || clear) |=> (acc_q == '0)); // R7

endmodule

// File: rtl/adcacc_fmt.sv
module adcacc_fmt #(
  parameter int SW = adcacc_pkg::SAMPLE_W,
  parameter int WW = adcacc_pkg::WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          last_take,
  input  logic          lj_eff,
  input  logic [WW-1:0] sum_next,
  output logic [WW-1:0] word_q,
  output logic          done_q
);

  localparam int PAD_W = WW - SW;

  function automatic logic [WW-1:0] place(input logic [WW-1:0] s, input logic lj);
    return lj ? {s[SW-1:0], {PAD_W{1'b0}}} : s;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      done_q <= 1'b0;
    end else if (clear) begin
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_take;
      if (last_take) word_q <= place(sum_next, lj_eff);
    end
  end

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !$past(clear)) |-> $stable(word_q)); // R10

  AST_LJ_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(lj_eff)) |-> (word_q[PAD_W-1:0] == '0)); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> ((word_q == '0) && !done_q)); // R8

endmodule

// File: rtl/adcacc_formatter.sv
module adcacc_formatter
  import adcacc_pkg::*;
#(
  parameter int SAMPLE_BITS = SAMPLE_W,
  parameter int WORD_BITS   = WORD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   clear,
  input  logic                   samp_vld,
  input  logic [SAMPLE_BITS-1:0] samp_data,
  input  logic [RPT_W-1:0]       rpt_sel,
  input  logic                   ljust_sel,
  output logic [7:0]             word_hi,
  output logic [7:0]             word_lo,
  output logic                   set_done
);

  localparam int HALF = WORD_BITS / 2;

  logic                 take_w;
  logic                 last_take_w;
  logic                 lj_eff_w;
  logic [CNT_W-1:0]     cnt_w;
  logic [WORD_BITS-1:0] sum_next_w;
  logic [WORD_BITS-1:0] word_w;

  always_comb begin
    take_w   = enable && samp_vld;
    lj_eff_w = lj_effective(rpt_sel, ljust_sel);
  end

  adcacc_count #(.CW(CNT_W), .RW(RPT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .take      (take_w),
    .rpt_sel   (rpt_sel),
    .cnt_q     (cnt_w),
    .last_take (last_take_w)
  );

  adcacc_sum #(.SW(SAMPLE_BITS), .WW(WORD_BITS)) u_sum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .take      (take_w),
    .last_take (last_take_w),
    .sample    (samp_data),
    .sum_next  (sum_next_w)
  );

  adcacc_fmt #(.SW(SAMPLE_BITS), .WW(WORD_BITS)) u_fmt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .last_take (last_take_w),
    .lj_eff    (lj_eff_w),
    .sum_next  (sum_next_w),
    .word_q    (word_w),
    .done_q    (set_done)
  );

  always_comb begin
    word_hi = word_w[WORD_BITS-1:HALF];
    word_lo = word_w[HALF-1:0];
  end

  AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |-> $past(take_w)); // R6

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(enable) && !$past(clear)) |-> $stable(cnt_w)); // R9

  AST_LJ_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_sel != '0) |-> !lj_eff_w); // R5

endmodule

// File: tb/adcacc_formatter_test.sv
module adcacc_formatter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        clear = 1'b0;
  logic        samp_vld = 1'b0;
  logic [11:0] samp_data = '0;
  logic [1:0]  rpt_sel = '0;
  logic        ljust_sel = 1'b0;
  logic [7:0]  word_hi;
  logic [7:0]  word_lo;
  logic        set_done;

  int compared = 0;
  int mismatched = 0;
  int held = 0;

  always #5 clk = ~clk;

  adcacc_formatter uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
    .samp_vld(samp_vld), .samp_data(samp_data), .rpt_sel(rpt_sel),
    .ljust_sel(ljust_sel), .word_hi(word_hi), .word_lo(word_lo),
    .set_done(set_done)
  );

  function automatic int set_size(input int r);
    if (r == 0) return 1;
    return 2 << r;
  endfunction

  function automatic int expect_word(input int sum, input int r, input int lj);
    if (lj != 0 && r == 0) return sum * 16;
    return sum;
  endfunction

  function automatic int word_now();
    return {word_hi, word_lo};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock with the given inputs; outputs are then read at the next negedge.
  task automatic cycle(input logic v, input logic [11:0] d, input logic en, input logic clr);
    samp_vld = v; samp_data = d; enable = en; clear = clr;
    @(negedge clk);
    samp_vld = 1'b0; clear = 1'b0;
  endtask

  task automatic run_set(input int r, input int lj, input int all_max, input string tag);
    int sum = 0;
    int n = set_size(r);
    int exp;
    rpt_sel = 2'(r);
    ljust_sel = 1'(lj);
    for (int i = 0; i < n; i++) begin
      logic [11:0] d = (all_max != 0) ? 12'hFFF : 12'($urandom);
      sum += d;
      cycle(1'b1, d, 1'b1, 1'b0);
      if (i < n - 1) begin
        check("R6 no pulse mid-set", set_done, 0);
        check("R10 word held", word_now(), held);
        if (($urandom & 3) == 0) begin
          cycle(1'b0, 12'($urandom), 1'b1, 1'b0);
          check("R6 no pulse when idle", set_done, 0);
        end
      end else begin
        exp = expect_word(sum, r, lj);
        check("R2 done on last sample", set_done, 1);
        check(tag, word_now(), exp);
        if (!(lj != 0 && r == 0))
          check("R3 unused top bits zero", word_now() >> (12 + ((r == 0) ? 0 : r + 1)), 0);
        held = exp;
      end
    end
    cycle(1'b0, 12'h0, 1'b1, 1'b0);
    check("R6 single-cycle pulse", set_done, 0);
  endtask

  initial begin
    void'($urandom(32'd24681));
    @(negedge clk);
    @(negedge clk);
    check("R1 reset word", word_now(), 0);
    check("R1 reset done", set_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 word after release", word_now(), 0);

    for (int r = 0; r < 4; r++) begin
      for (int lj = 0; lj < 2; lj++) begin
        for (int k = 0; k < 3; k++) begin
          if (lj == 1 && r == 0)      run_set(r, lj, 0, "R4 left placed");
          else if (lj == 1)           run_set(r, lj, 0, "R5 fallback right");
          else if (k > 0)             run_set(r, lj, 0, "R7 fresh set sum");
          else                        run_set(r, lj, 0, "R2 set sum");
        end
      end
    end
    run_set(3, 0, 1, "R3 full-scale 16-sum");
    check("R3 full scale 0xFFF0", word_now(), 16'hFFF0);
    run_set(0, 1, 1, "R4 full-scale left");

    // R9: disabled samples ignored
    rpt_sel = 2'd1; ljust_sel = 1'b0;
    cycle(1'b1, 12'h800, 1'b0, 1'b0);
    cycle(1'b1, 12'h800, 1'b0, 1'b0);
    check("R9 no pulse while disabled", set_done, 0);
    check("R9 word unchanged while disabled", word_now(), held);
    cycle(1'b1, 12'h001, 1'b1, 1'b0);
    cycle(1'b1, 12'h002, 1'b1, 1'b0);
    cycle(1'b1, 12'h800, 1'b0, 1'b0);
    cycle(1'b1, 12'h003, 1'b1, 1'b0);
    check("R9 set not done early", set_done, 0);
    cycle(1'b1, 12'h004, 1'b1, 1'b0);
    check("R9 done after 4 enabled", set_done, 1);
    check("R9 disabled samples excluded", word_now(), 10);

    // R8: clear mid-set, with a simultaneous sample
    rpt_sel = 2'd2;
    cycle(1'b1, 12'h111, 1'b1, 1'b0);
    cycle(1'b1, 12'h222, 1'b1, 1'b0);
    cycle(1'b1, 12'h333, 1'b1, 1'b1);
    check("R8 word cleared", word_now(), 0);
    check("R8 no pulse on clear", set_done, 0);
    held = 0;
    run_set(2, 0, 0, "R8 set after clear is fresh");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule